// File: doc/BRIEF.md
# eMMC Command Line Engine

This block sends one command frame at a time on the single shared command wire of an eMMC device and, when asked, collects the device's reply. The host side hands over a 6-bit command index and a 32-bit argument with a one-cycle request. The engine adds the start, direction, CRC and stop bits itself and shifts the 48-bit frame out, most significant bit first. It moves one bit per clock-enable pulse, so the bit rate on the wire comes from whoever generates the enable.

The wire is shared, with a pull-up, and the engine signals on it open-drain style. A zero is sent by driving the pad low; a one is sent by releasing the pad. When the frame is finished the engine stops driving. If a reply was requested, it waits for the device to pull the wire low as a start bit and shifts in a 48-bit reply. It then checks the reply's framing and CRC and reports the reply argument. If the wire stays high for too long, it reports a timeout instead. Commands with no reply end as soon as the stop bit has gone out.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After reset, or when reset is applied in the middle of a command, `busy`, `done`, `crc_err`, `timeout` and `cmd_oe` are all 0, so the wire is released.
- R2: The transmitted frame is 48 bits, sent MSB first: a start bit 0, a direction bit 1, the 6-bit index, the 32-bit argument, a 7-bit CRC, then a stop bit 1. For index 6, the first eight bits on the wire read 0x46.
- R3: The CRC is produced by the engine. It uses the polynomial x^7+x^3+1 with an all-zero start value, taken over the first 40 frame bits. Index 0 with a zero argument gives CRC 0x4A.
- R4: `cmd_out` is always 0, and `cmd_oe` is 1 only while a 0 bit is being sent. The pad is released for 1 bits, for the stop bit, while waiting for the reply, while receiving it, and while idle.
- R5: The frame advances one bit per cycle with `ce` high. With `ce` low, `cmd_oe` holds its value.
- R6: When `req_resp` is 0, `done` pulses and `busy` falls at the clock edge that launches the stop bit.
- R7: When `req_resp` is 1, the first 0 sampled after the stop bit starts a 48-bit reply. At the `ce` edge that samples the reply's last bit, `done` pulses, `busy` falls and `rsp_arg` takes reply bits 39..8.
- R8: `crc_err` is set with `done` if the reply's CRC over its first 40 bits does not match its bits 7..1. It is also set if the reply's second bit is 1, or if its stop bit is 0.
- R9: If the wire is sampled high on 64 consecutive `ce` pulses after the stop bit, `timeout` is set together with `done` and the engine returns to idle. A start bit seen on the 64th sample is still accepted.
- R10: `busy` rises on the clock after an accepted request and stays high until `done`. A request made while `busy` is high is ignored and changes neither the frame in flight nor the state after it.
- R11: `done` lasts exactly one clock. `crc_err` and `timeout` hold their value until the next request is accepted, and they are cleared then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Bit-time enable; one wire bit per pulse |
| req_valid | input | 1 | Request a command (taken when idle) |
| req_idx | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_resp | input | 1 | 1 = expect a 48-bit reply |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| rsp_arg | output | 32 | Argument field of the last reply |
| crc_err | output | 1 | Reply CRC or framing error |
| timeout | output | 1 | No reply start bit in time |
| cmd_oe | output | 1 | Pad output enable |
| cmd_out | output | 1 | Pad output value (always 0) |
| cmd_in | input | 1 | Sampled command wire |

## Verification
The hardest cases to reach from the ports are the two sides of the reply window: a start bit that arrives on exactly the 64th enable pulse, and a wire that stays high through that pulse. To reach them, the bench models the device as an open-drain agent that decodes the host frame from the wire. It then holds the wire released for a programmed number of bit times before pulling it low. Delays of 63 and 64 put the reply start on each side of the limit. Other cases corrupt a CRC bit or the direction bit of the reply. Enable gaps are placed between all bits, and a second request is fired in the middle of a frame.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
  localparam int IDX_W   = 6;
  localparam int ARG_W   = 32;
  localparam int CRC_W   = 7;
  localparam int HDR_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = HDR_W + CRC_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RX   = 2'd3
  } cmd_state_e;

  // x^7 + x^3 + 1, zero seed, MSB first
  function automatic logic [CRC_W-1:0] crc7_calc(input logic [HDR_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = HDR_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[6];
      c  = {c[5:3], c[2] ^ fb, c[1:0], fb};
    end
    return c;
  endfunction
endpackage

// File: rtl/mmc_cmd_ser.sv
module mmc_cmd_ser #(
  parameter int W  = 48,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] frame,
  input  logic         adv,
  output logic         tx_bit,
  output logic         tx_last
);
  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '1;
      cnt  <= '0;
    end else if (load) begin
      sreg <= frame;
      cnt  <= '0;
    end else if (adv) begin
      sreg <= {sreg[W-2:0], 1'b1};
      cnt  <= cnt + 1'b1;
    end
  end

  assign tx_bit  = sreg[W-1];
  assign tx_last = (cnt == CW'(W - 1));
endmodule

// File: rtl/mmc_rsp_des.sv
module mmc_rsp_des #(
  parameter int W  = 48,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic         din,
  output logic [W-1:0] frame,
  output logic         full
);
  logic [W-2:0]  sreg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (adv) begin
      sreg <= {sreg[W-3:0], din};
      cnt  <= cnt + 1'b1;
    end
  end

  // frame as it stands including the bit being sampled now
  assign frame = {sreg, din};
  assign full  = adv && (cnt == CW'(W - 1));
endmodule

// File: rtl/mmc_rsp_timer.sv
module mmc_rsp_timer #(
  parameter int LIMIT = 64,
  localparam int TW   = $clog2(LIMIT) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic adv,
  output logic expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (adv)   cnt <= cnt + 1'b1;
  end

  assign expired = adv && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
  import mmc_cmd_pkg::*;
#(
  parameter int TMO_LIMIT = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [ARG_W-1:0] req_arg,
  input  logic             req_resp,
  output logic             busy,
  output logic             done,
  output logic [ARG_W-1:0] rsp_arg,
  output logic             crc_err,
  output logic             timeout,
  output logic             cmd_oe,
  output logic             cmd_out,
  input  logic             cmd_in
);
  localparam int ARG_LO = CRC_W + 1;

  cmd_state_e st;
  logic want_rsp;
  logic accept;
  logic [HDR_W-1:0]   tx_hdr;
  logic [FRAME_W-1:0] tx_frame;
  logic tx_bit, tx_last;
  logic rx_adv, rx_full;
  logic [FRAME_W-1:0] rx_frame;
  logic tmr_adv, tmr_exp;
  logic rx_bad;

  assign accept   = (st == ST_IDLE) && req_valid;
  assign tx_hdr   = {2'b01, req_idx, req_arg};
  assign tx_frame = {tx_hdr, crc7_calc(tx_hdr), 1'b1};
  assign cmd_out  = 1'b0;

  mmc_cmd_ser #(.W(FRAME_W)) u_ser (
    .clk(clk), .rst(rst), .load(accept), .frame(tx_frame),
    .adv(ce && st == ST_TX), .tx_bit(tx_bit), .tx_last(tx_last)
  );

  assign rx_adv = ce && ((st == ST_WAIT && !cmd_in) || st == ST_RX);

  mmc_rsp_des #(.W(FRAME_W)) u_des (
    .clk(clk), .rst(rst), .clr(accept), .adv(rx_adv), .din(cmd_in),
    .frame(rx_frame), .full(rx_full)
  );

  assign tmr_adv = ce && st == ST_WAIT && cmd_in;

  mmc_rsp_timer #(.LIMIT(TMO_LIMIT)) u_tmr (
    .clk(clk), .rst(rst), .clr(accept), .adv(tmr_adv), .expired(tmr_exp)
  );

  assign rx_bad = rx_frame[FRAME_W-2] || !rx_frame[0] ||
                  (rx_frame[CRC_W:1] != crc7_calc(rx_frame[FRAME_W-1:ARG_LO]));

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      want_rsp <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rsp_arg  <= '0;
      crc_err  <= 1'b0;
      timeout  <= 1'b0;
      cmd_oe   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          busy     <= 1'b1;
          crc_err  <= 1'b0;
          timeout  <= 1'b0;
          want_rsp <= req_resp;
          st       <= ST_TX;
        end
        ST_TX: if (ce) begin
          cmd_oe <= ~tx_bit;
          if (tx_last) begin
            if (want_rsp) st <= ST_WAIT;
            else begin
              st   <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        ST_WAIT: if (ce) begin
          if (!cmd_in) st <= ST_RX;
          else if (tmr_exp) begin
            timeout <= 1'b1;
            done    <= 1'b1;
            busy    <= 1'b0;
            st      <= ST_IDLE;
          end
        end
        ST_RX: if (rx_full) begin
          rsp_arg <= rx_frame[ARG_LO +: ARG_W];
          crc_err <= rx_bad;
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmc_cmd_engine_chk.sv
module mmc_cmd_engine_chk (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic crc_err,
  input logic timeout,
  input logic cmd_oe
);
  // R4
  idle_released_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_oe);

  // R5
  hold_without_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cmd_oe));

  // R6
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  crc_err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err) |-> done);

  // R9
  timeout_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done);

  // R10
  busy_from_request_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind mmc_cmd_engine mmc_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .ce(ce), .req_valid(req_valid), .busy(busy),
  .done(done), .crc_err(crc_err), .timeout(timeout), .cmd_oe(cmd_oe)
);

// File: tb/sim_mmc_cmd_engine.sv
module sim_mmc_cmd_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic req_valid = 1'b0;
  logic [5:0] req_idx = '0;
  logic [31:0] req_arg = '0;
  logic req_resp = 1'b0;
  logic busy, done, crc_err, timeout, cmd_oe, cmd_out;
  logic [31:0] rsp_arg;
  logic dev_low = 1'b0;
  logic line;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign line = !((cmd_oe && !cmd_out) || dev_low);

  mmc_cmd_engine u0 (
    .clk(clk), .rst(rst), .ce(ce), .req_valid(req_valid), .req_idx(req_idx),
    .req_arg(req_arg), .req_resp(req_resp), .busy(busy), .done(done),
    .rsp_arg(rsp_arg), .crc_err(crc_err), .timeout(timeout),
    .cmd_oe(cmd_oe), .cmd_out(cmd_out), .cmd_in(line)
  );

  // idx, arg, resp, delay, reply arg, mode (0 ok, 1 bad crc, 2 direction bit set)
  localparam logic [79:0] VECS [7] = '{
    {6'd0,  32'h0000_0000, 1'b0, 7'd0,  32'h0000_0000, 2'd0},
    {6'd6,  32'h03B7_0100, 1'b1, 7'd2,  32'h0000_0900, 2'd0},
    {6'd17, 32'h0000_0000, 1'b1, 7'd0,  32'h1234_5678, 2'd1},
    {6'd13, 32'h0001_0000, 1'b1, 7'd63, 32'h0000_0700, 2'd0},
    {6'd19, 32'hA5A5_5A5A, 1'b1, 7'd64, 32'h0000_0000, 2'd0},
    {6'd8,  32'h0000_01AA, 1'b1, 7'd5,  32'hCAFE_F00D, 2'd2},
    {6'd63, 32'hFFFF_FFFF, 1'b0, 7'd0,  32'h0000_0000, 2'd0}
  };

  function automatic logic [6:0] crc7b(input logic [39:0] d);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic m;
      m = c[6] ^ d[i];
      c = c << 1;
      if (m) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [5:0] idx, input logic [31:0] arg, input logic resp,
                     input int delay, input logic [31:0] rarg, input int mode);
    logic [47:0] got, exp, rf;
    bit gap_ok, oe_ok;
    int n;
    exp = {2'b01, idx, arg, crc7b({2'b01, idx, arg}), 1'b1};
    @(negedge clk);
    req_idx = idx; req_arg = arg; req_resp = resp; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", 64'(busy), 64'd1);
    chk(!crc_err && !timeout, "R11 flags cleared on accept", 64'({crc_err, timeout}), 64'd0);
    repeat (3) @(negedge clk);
    chk(cmd_oe == 1'b0 && busy, "R5 no bit without ce", 64'(cmd_oe), 64'd0);
    gap_ok = 1'b1; oe_ok = 1'b1;
    for (int b = 0; b < 48; b++) begin
      @(negedge clk);
      ce = 1'b1;
      if (b == 10) begin
        req_valid = 1'b1; req_idx = ~idx; req_arg = ~arg; req_resp = ~resp;
      end
      @(posedge clk); #1;
      got[47-b] = line;
      if (cmd_oe != !line) oe_ok = 1'b0;
      if (b == 47) begin
        if (!resp) chk(done && !busy, "R6 done at stop bit", 64'({done, busy}), 64'b10);
        else chk(!done && busy, "R7 still busy after stop", 64'({done, busy}), 64'b01);
      end
      @(negedge clk);
      ce = 1'b0; req_valid = 1'b0;
      @(posedge clk); #1;
      if (line != got[47-b]) gap_ok = 1'b0;
    end
    chk(gap_ok, "R5 hold during ce gap", 64'(gap_ok), 64'd1);
    chk(oe_ok, "R4 drive only for zero", 64'(oe_ok), 64'd1);
    chk(got == exp, "R2 frame bits", 64'(got), 64'(exp));
    if (idx == 6'd6) chk(got[47:40] == 8'h46, "R2 first byte", 64'(got[47:40]), 64'h46);
    if (idx == 6'd0 && arg == 32'd0) chk(got[7:1] == 7'h4A, "R3 crc known value", 64'(got[7:1]), 64'h4A);
    chk(got[7:1] == crc7b(got[47:8]), "R3 crc field", 64'(got[7:1]), 64'(crc7b(got[47:8])));
    if (resp) begin
      rf = {2'b00, idx, rarg, crc7b({2'b00, idx, rarg}), 1'b1};
      if (mode == 1) rf[1] = ~rf[1];
      if (mode == 2) rf = {2'b01, idx, rarg, crc7b({2'b01, idx, rarg}), 1'b1};
      n = (delay >= 64) ? 64 : delay + 48;
      oe_ok = 1'b1;
      for (int t = 0; t < n; t++) begin
        @(negedge clk);
        ce = 1'b1;
        dev_low = (t >= delay) ? !rf[47-(t-delay)] : 1'b0;
        @(posedge clk); #1;
        if (cmd_oe) oe_ok = 1'b0;
        if (t == n - 1)
          chk(done && !busy, "R7 done at last reply bit", 64'({done, busy}), 64'b10);
        else if (!busy || done) begin
          chk(1'b0, "R10 busy until done", 64'({done, busy}), 64'b01);
        end
        @(negedge clk);
        ce = 1'b0; dev_low = 1'b0;
      end
      chk(oe_ok, "R4 released while waiting", 64'(oe_ok), 64'd1);
      @(negedge clk);
      chk(!done, "R11 done one clock", 64'(done), 64'd0);
      if (delay >= 64) begin
        chk(timeout && !crc_err, "R9 timeout at 64", 64'({timeout, crc_err}), 64'b10);
      end else begin
        chk(!timeout, "R9 no timeout within 64", 64'(timeout), 64'd0);
        chk(crc_err == (mode != 0), "R8 crc_err", 64'(crc_err), 64'(mode != 0));
        if (mode == 0) chk(rsp_arg == rarg, "R7 reply arg", 64'(rsp_arg), 64'(rarg));
      end
    end else begin
      @(negedge clk);
      chk(!done && !timeout && !crc_err, "R11 flags after no-reply", 64'({done, timeout, crc_err}), 64'd0);
    end
    gap_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); ce = 1'b1;
      @(posedge clk); #1;
      if (!line || busy) gap_ok = 1'b0;
    end
    @(negedge clk); ce = 1'b0;
    chk(gap_ok, "R10 ignored request left idle", 64'(gap_ok), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, crc_err, timeout, cmd_oe} == 5'd0, "R1 reset state",
        64'({busy, done, crc_err, timeout, cmd_oe}), 64'd0);
    for (int i = 0; i < 7; i++) begin
      logic [79:0] v;
      v = VECS[i];
      run(v[79:74], v[73:42], v[41], int'(v[40:34]), v[33:2], int'(v[1:0]));
    end
    // reset in the middle of a frame
    @(negedge clk);
    req_idx = 6'd2; req_arg = 32'h0; req_resp = 1'b1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    for (int b = 0; b < 5; b++) begin
      @(negedge clk); ce = 1'b1;
      @(negedge clk); ce = 1'b0;
    end
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, cmd_oe, done} == 3'd0, "R1 reset mid command", 64'({busy, cmd_oe, done}), 64'd0);
    run(6'd6, 32'h0000_0001, 1'b1, 1, 32'h0000_0ACE, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule